// File: doc/BRIEF.md
# CDS Integration Timing Sequencer

This block generates the per-pixel control waveforms for a dual-ramp correlated double sampler, and it issues the pulse that starts the downstream converter. It runs from one fixed system clock. Every duration is a parameter counted in clock cycles. Each pixel period starts with a one-cycle start strobe. Then the block opens the reset-level integrator enable, leaves a guard gap, opens the signal-level integrator enable for the same width, and finally raises a conversion trigger after the signal window has ended. The rest of the period stays quiet.

Each integrator enable brackets its integration window by a pad of `PAD_CYC` cycles on both sides. The gap between the two windows is wider than two pads, so the enables never overlap. A rate input selects the fast or the slow readout. The slow rate multiplies every start position, every width and the period by `SLOW_MUL`. At the defaults (100 MHz clock) this gives a 10 µs period with 4 µs windows, 4.8 µs enables, a 1 µs gap and a 500 ns trigger. With `SLOW_MUL` = 2 the period becomes 20 µs.

The run and rate inputs are read only at a period boundary, so a period is never cut short or stretched. The outputs are registered and aligned with the internal counter. The cycle in which the counter holds position p of a period is the cycle in which the outputs show position p.

Top module: `cds_int_seq`

## Requirements
- R1: While reset is active, and while idle with run_i low, start_o, ph_rst_o, ph_sig_o and conv_o are all 0.
- R2: If run_i is sampled high at a clock edge while idle, position 0 of a period begins at that edge. start_o is high for exactly one cycle, at position 0 of every period.
- R3: With rate_i = 0 a period lasts PERIOD_CYC cycles. While run_i stays high, periods follow each other with no idle cycle in between.
- R4: ph_rst_o is high exactly at positions p with LEAD_CYC ≤ p < LEAD_CYC + INT_CYC + 2·PAD_CYC.
- R5: ph_sig_o is high exactly at positions LEAD_CYC + INT_CYC + GAP_CYC ≤ p < that start + INT_CYC + 2·PAD_CYC, which is the same width as ph_rst_o.
- R6: ph_rst_o and ph_sig_o are never high in the same cycle.
- R7: conv_o is high exactly at positions s ≤ p < s + TRIG_CYC, where s = LEAD_CYC + PAD_CYC + 2·INT_CYC + GAP_CYC + TRIG_DLY_CYC, that is after the signal window has ended.
- R8: With rate_i = 1 (slow), the period and every start position and width in R4, R5 and R7 are multiplied by SLOW_MUL.
- R9: rate_i is read only at the edge that begins a period. A change of rate_i inside a period does not affect that period, and the next period uses the new rate.
- R10: If run_i is sampled low at the edge that ends the last cycle of a period, the block goes idle and all outputs stay 0. If run_i goes low earlier in a period, that period still completes in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable, read while idle and at period end |
| rate_i | input | 1 | Readout rate: 0 fast, 1 slow |
| start_o | output | 1 | One-cycle strobe at position 0 of each period |
| ph_rst_o | output | 1 | Reset-level integrator enable |
| ph_sig_o | output | 1 | Signal-level integrator enable |
| conv_o | output | 1 | Conversion trigger pulse |

## Verification
Every output is due in the cycle that directly follows the clock edge at which the inputs are sampled. If run_i is seen high at an idle edge, start_o is visible in the very next cycle, and position p of the period is visible p cycles after that. The bench drives its inputs on falling edges. On each rising edge it advances its own position counter from the requirements, and on the next falling edge it compares all four outputs against the window arithmetic for that position. A rate change or a drop of run_i therefore shows up exactly one period boundary later, and never sooner.

// File: rtl/cds_seq_pkg.sv
package cds_seq_pkg;

  localparam int unsigned NUM_WIN = 3;
  localparam int unsigned WIN_A   = 0;  // reset-level enable
  localparam int unsigned WIN_B   = 1;  // signal-level enable
  localparam int unsigned WIN_T   = 2;  // conversion trigger

  // first active position of window w at the fast rate
  function automatic int unsigned win_start(int unsigned w, int unsigned lead,
                                            int unsigned pad, int unsigned iw,
                                            int unsigned gap, int unsigned dly);
    case (w)
      WIN_A:   return lead;
      WIN_B:   return lead + iw + gap;
      default: return lead + pad + 2 * iw + gap + dly;
    endcase
  endfunction

  // width of window w at the fast rate
  function automatic int unsigned win_len(int unsigned w, int unsigned pad,
                                          int unsigned iw, int unsigned trig);
    case (w)
      WIN_A, WIN_B: return iw + 2 * pad;
      default:      return trig;
    endcase
  endfunction

endpackage

// File: rtl/cds_period_ctr.sv
module cds_period_ctr #(
  parameter int unsigned PERIOD_CYC = 1000,
  parameter int unsigned SLOW_MUL   = 2,
  parameter int unsigned CNT_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rate_i,
  output logic             act_nxt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             slow_nxt_o,
  output logic             act_q_o,
  output logic             slow_q_o
);

  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(PERIOD_CYC * SLOW_MUL - 1);

  logic             act_q, slow_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = act_q && (cnt_q == (slow_q ? LAST_S : LAST_F));

  always_comb begin
    act_nxt_o  = act_q;
    cnt_nxt_o  = cnt_q;
    slow_nxt_o = slow_q;
    if (!act_q) begin
      if (run_i) begin
        act_nxt_o  = 1'b1;
        cnt_nxt_o  = '0;
        slow_nxt_o = rate_i;
      end
    end else if (wrap) begin
      cnt_nxt_o = '0;
      if (run_i) slow_nxt_o = rate_i;
      else       act_nxt_o  = 1'b0;
    end else begin
      cnt_nxt_o = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      act_q  <= act_nxt_o;
      cnt_q  <= cnt_nxt_o;
      slow_q <= slow_nxt_o;
    end
  end

  assign act_q_o  = act_q;
  assign slow_q_o = slow_q;

endmodule

// File: rtl/cds_win_dec.sv
module cds_win_dec #(
  parameter int unsigned START_F  = 0,
  parameter int unsigned LEN_F    = 1,
  parameter int unsigned SLOW_MUL = 2,
  parameter int unsigned CNT_W    = 11
) (
  input  logic             act_i,
  input  logic             slow_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);

  localparam logic [CNT_W:0] LO_F = (CNT_W+1)'(START_F);
  localparam logic [CNT_W:0] HI_F = (CNT_W+1)'(START_F + LEN_F);
  localparam logic [CNT_W:0] LO_S = (CNT_W+1)'(START_F * SLOW_MUL);
  localparam logic [CNT_W:0] HI_S = (CNT_W+1)'((START_F + LEN_F) * SLOW_MUL);

  logic [CNT_W:0] pos, lo, hi;

  assign pos   = {1'b0, cnt_i};
  assign lo    = slow_i ? LO_S : LO_F;
  assign hi    = slow_i ? HI_S : HI_F;
  assign hit_o = act_i && (pos >= lo) && (pos < hi);

endmodule

// File: rtl/cds_out_reg.sv
module cds_out_reg #(
  parameter int unsigned NW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_d_i,
  input  logic [NW-1:0] win_d_i,
  output logic          strobe_q_o,
  output logic [NW-1:0] win_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q_o <= 1'b0;
      win_q_o    <= '0;
    end else begin
      strobe_q_o <= strobe_d_i;
      win_q_o    <= win_d_i;
    end
  end

endmodule

// File: rtl/cds_int_seq.sv
module cds_int_seq
  import cds_seq_pkg::*;
#(
  parameter int unsigned PERIOD_CYC   = 1000,
  parameter int unsigned LEAD_CYC     = 5,
  parameter int unsigned INT_CYC      = 400,
  parameter int unsigned GAP_CYC      = 100,
  parameter int unsigned PAD_CYC      = 40,
  parameter int unsigned TRIG_DLY_CYC = 0,
  parameter int unsigned TRIG_CYC     = 50,
  parameter int unsigned SLOW_MUL     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rate_i,
  output logic start_o,
  output logic ph_rst_o,
  output logic ph_sig_o,
  output logic conv_o
);

  localparam int unsigned CNT_W = $clog2(PERIOD_CYC * SLOW_MUL);

  logic               act_nxt, slow_nxt, act_q, slow_q;
  logic [CNT_W-1:0]   cnt_nxt;
  logic               start_d, start_q;
  logic [NUM_WIN-1:0] win_d, win_q;

  cds_period_ctr #(
    .PERIOD_CYC(PERIOD_CYC),
    .SLOW_MUL  (SLOW_MUL),
    .CNT_W     (CNT_W)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .rate_i    (rate_i),
    .act_nxt_o (act_nxt),
    .cnt_nxt_o (cnt_nxt),
    .slow_nxt_o(slow_nxt),
    .act_q_o   (act_q),
    .slow_q_o  (slow_q)
  );

  assign start_d = act_nxt && (cnt_nxt == '0);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    cds_win_dec #(
      .START_F (win_start(w, LEAD_CYC, PAD_CYC, INT_CYC, GAP_CYC, TRIG_DLY_CYC)),
      .LEN_F   (win_len(w, PAD_CYC, INT_CYC, TRIG_CYC)),
      .SLOW_MUL(SLOW_MUL),
      .CNT_W   (CNT_W)
    ) u_dec (
      .act_i (act_nxt),
      .slow_i(slow_nxt),
      .cnt_i (cnt_nxt),
      .hit_o (win_d[w])
    );
  end

  // outputs registered from next-state so they line up with the counter
  cds_out_reg #(.NW(NUM_WIN)) u_oreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_d_i(start_d),
    .win_d_i   (win_d),
    .strobe_q_o(start_q),
    .win_q_o   (win_q)
  );

  assign start_o  = start_q;
  assign ph_rst_o = win_q[WIN_A];
  assign ph_sig_o = win_q[WIN_B];
  assign conv_o   = win_q[WIN_T];

endmodule

// File: rtl/cds_int_seq_chk.sv
module cds_int_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_o,
  input logic ph_rst_o,
  input logic ph_sig_o,
  input logic conv_o,
  input logic act_q,
  input logic slow_q
);

  logic [15:0] a_len, b_len, a_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_len  <= '0;
      b_len  <= '0;
      a_last <= '0;
    end else begin
      a_len <= ph_rst_o ? a_len + 16'd1 : '0;
      b_len <= ph_sig_o ? b_len + 16'd1 : '0;
      if (!ph_rst_o && a_len != '0) a_last <= a_len;
    end
  end

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph_rst_o && ph_sig_o));

  p_strobe_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_ab_equal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_sig_o) |-> (b_len == a_last));

  p_trig_late_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> !ph_rst_o);

  p_rate_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(slow_q));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !(start_o || ph_rst_o || ph_sig_o || conv_o));

endmodule

bind cds_int_seq cds_int_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_o (start_o),
  .ph_rst_o(ph_rst_o),
  .ph_sig_o(ph_sig_o),
  .conv_o  (conv_o),
  .act_q   (act_q),
  .slow_q  (slow_q)
);

// File: tb/tb_cds_int_seq.sv
module tb_cds_int_seq;

  localparam int P    = 40;
  localparam int LEAD = 2;
  localparam int IW   = 8;
  localparam int GAP  = 6;
  localparam int PAD  = 2;
  localparam int DLY  = 1;
  localparam int TW   = 3;
  localparam int MUL  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic run_i = 1'b0;
  logic rate_i = 1'b0;
  logic start_o, ph_rst_o, ph_sig_o, conv_o;

  always #4 clk = ~clk;

  cds_int_seq #(
    .PERIOD_CYC(P), .LEAD_CYC(LEAD), .INT_CYC(IW), .GAP_CYC(GAP),
    .PAD_CYC(PAD), .TRIG_DLY_CYC(DLY), .TRIG_CYC(TW), .SLOW_MUL(MUL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .rate_i(rate_i),
    .start_o(start_o), .ph_rst_o(ph_rst_o), .ph_sig_o(ph_sig_o), .conv_o(conv_o)
  );

  int    checks = 0;
  int    errors = 0;
  string seg = "R1";
  bit    done = 0;

  // requirement model: position within the current period
  bit m_act, m_slow;
  int m_pos;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_pos = 0; m_slow = 0;
    end else if (!m_act) begin
      if (run_i) begin m_act = 1; m_pos = 0; m_slow = rate_i; end
    end else if (m_pos == P * (m_slow ? MUL : 1) - 1) begin
      m_pos = 0;
      if (run_i) m_slow = rate_i;
      else       m_act = 0;
    end else begin
      m_pos = m_pos + 1;
    end
  end

  function automatic bit inwin(int pos, int s, int l, int k);
    return (pos >= s * k) && (pos < (s + l) * k);
  endfunction

  task automatic chk(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at %0t", seg, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      automatic int k  = m_slow ? MUL : 1;
      automatic bit es = m_act && (m_pos == 0);
      automatic bit ea = m_act && inwin(m_pos, LEAD, IW + 2*PAD, k);
      automatic bit eb = m_act && inwin(m_pos, LEAD + IW + GAP, IW + 2*PAD, k);
      automatic bit et = m_act && inwin(m_pos, LEAD + PAD + 2*IW + GAP + DLY, TW, k);
      chk("R2 start", start_o, es);
      chk("R4 ph_rst", ph_rst_o, ea);
      chk("R5 ph_sig", ph_sig_o, eb);
      chk("R7 conv", conv_o, et);
      chk("R6 excl", ph_rst_o & ph_sig_o, 1'b0);
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    seg = "R1";
    repeat (6) @(negedge clk);
    seg = "R3";
    run_i = 1'b1; rate_i = 1'b0;
    repeat (3 * P + 7) @(negedge clk);
    seg = "R9";
    rate_i = 1'b1;                       // mid fast period
    repeat (P) @(negedge clk);
    seg = "R8";
    repeat (3 * P * MUL) @(negedge clk);
    seg = "R9";
    repeat (11) @(negedge clk);
    rate_i = 1'b0;                       // mid slow period
    repeat (2 * P * MUL) @(negedge clk);
    seg = "R10";
    repeat (13) @(negedge clk);
    run_i = 1'b0;                        // mid period: must finish
    repeat (3 * P * MUL) @(negedge clk);
    run_i = 1'b1; rate_i = 1'b1;         // one-cycle pulse while idle
    @(negedge clk);
    run_i = 1'b0;
    repeat (2 * P * MUL + 5) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule